// File: doc/BRIEF.md
# Conditional FP Move Predicate Evaluator

This block decides whether a conditional floating-point move executes. It takes the instruction word, the FP status word with its four 2-bit compare fields, the integer flag byte and the value of the integer source register. It returns a take/skip decision and the class of the predicate source. The decode sorts each instruction into one of three predicate sources. The first is an FP compare field. The second is an integer flag nibble, in 32-bit or 64-bit form. The third is the zero or sign state of a register. Each source has its own condition table and its own inversion bit.

A surrounding pipeline uses the decision to do one of two things. It turns a taken move into a plain move. It turns a skipped move into a no-op that clears the current-exception field and advances the PC. The decision is registered. It appears one cycle after a `valid_i` strobe and holds until the next strobe.

Instruction fields used below:
- Format check: `insn[31:30]=2'b10` and `insn[24:19]=6'h35`.
- Operation field: `opf=insn[13:5]`.
- Condition / register specifier field: `insn[18:14]`.

Class codes on `cls_o`: 0 none, 1 FP compare, 2 integer flags, 3 register.

Top module: `fmov_pred_eval`

## Requirements
- R1: An FP-compare move has `opf[8]=0`, `opf[5:0]=6'h03` and class code 1. `insn[12:11]` picks the compare field: 0 uses status bits 11:10, while 1, 2 and 3 use status bits 33:32, 35:34 and 37:36.
- R2: FP compare values are 0 equal, 1 less, 2 greater, 3 unordered. `insn[16:14]` selects the test as follows:
  - 0: never
  - 1: not equal
  - 2: less or greater
  - 3: unordered or less
  - 4: less
  - 5: unordered or greater
  - 6: greater
  - 7: unordered
- R3: For the FP-compare and integer-flag classes, `insn[17]` inverts the tested predicate. So a condition of 4'h8 always takes.
- R4: An integer-flag move has opf 9'h103 (class code 2). It uses the low nibble of the flag byte. Opf 9'h183 (`insn[12]=1`) uses the high nibble. The nibble bits are N=3, Z=2, V=1, C=0.
- R5: `insn[16:14]` selects the integer test as follows:
  - 0: never
  - 1: Z
  - 2: Z or (N xor V)
  - 3: N xor V
  - 4: C or Z
  - 5: C
  - 6: N
  - 7: V
- R6: A register move has `opf[8]=0`, `opf[4:0]=5'h07`, and a test code `insn[11:10]` that is not zero (class code 3). The test code is compared against the signed 64-bit register value: 1 is equal to zero, 2 is less than or equal to zero, 3 is less than zero.
- R7: For the register class, `insn[12]` inverts the result.
- R8: A register specifier `insn[18:14]` of 0 reads as the value zero, whatever `rs_val_i` holds.
- R9: An instruction that matches no class, or fails the format check, gives class 0 and take 0.
- R10: `valid_o` follows `valid_i` by one cycle. `take_o` and `cls_o` update only after a strobe and otherwise hold.
- R11: While reset is asserted, `valid_o`, `take_o` and `cls_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Strobe: evaluate the inputs this cycle |
| insn_i | input | 32 | Instruction word |
| status_i | input | 64 | FP status word holding the four compare fields |
| flags_i | input | 8 | Integer flag byte: low nibble 32-bit, high nibble 64-bit |
| rs_val_i | input | 64 | Integer source register value |
| valid_o | output | 1 | Decision valid, one cycle after the strobe |
| take_o | output | 1 | 1 = move executes, 0 = becomes a no-op |
| cls_o | output | 2 | Predicate source class |

## Verification
The assertions assume that `valid_i` and `insn_i` are defined and stable around each rising edge while reset is released. They also assume the instruction encodings above are the only ones that map to a class. The scoreboard driver changes every input only on the falling edge. It builds each instruction from the format check plus the class-specific opf, so no word falls into two classes. The unrecognised words it sends differ from a valid encoding in exactly one field.

// File: rtl/fmov_pred_pkg.sv
package fmov_pred_pkg;
  typedef enum logic [1:0] {
    CLS_NONE = 2'd0,
    CLS_FCC  = 2'd1,
    CLS_INT  = 2'd2,
    CLS_REG  = 2'd3
  } pred_cls_e;

  localparam int unsigned FCC_N = 4;

  function automatic int unsigned fcc_lsb(input int unsigned idx);
    return (idx == 0) ? 10 : 30 + 2 * idx;
  endfunction
endpackage

// File: rtl/fcc_pred.sv
module fcc_pred (
  input  logic [3:0] cond_i,
  input  logic [1:0] fcc_i,
  output logic       take_o
);
  logic lt, gt, un, eq, raw;
  always_comb begin
    eq = (fcc_i == 2'd0);
    lt = (fcc_i == 2'd1);
    gt = (fcc_i == 2'd2);
    un = (fcc_i == 2'd3);
    unique case (cond_i[2:0])
      3'd0: raw = 1'b0;
      3'd1: raw = !eq;
      3'd2: raw = lt | gt;
      3'd3: raw = un | lt;
      3'd4: raw = lt;
      3'd5: raw = un | gt;
      3'd6: raw = gt;
      default: raw = un;
    endcase
    take_o = raw ^ cond_i[3];
  end
endmodule

// File: rtl/icc_pred.sv
module icc_pred (
  input  logic [3:0] cond_i,
  input  logic [3:0] nzvc_i,
  output logic       take_o
);
  logic n, z, v, c, raw;
  always_comb begin
    {n, z, v, c} = nzvc_i;
    unique case (cond_i[2:0])
      3'd0: raw = 1'b0;
      3'd1: raw = z;
      3'd2: raw = z | (n ^ v);
      3'd3: raw = n ^ v;
      3'd4: raw = c | z;
      3'd5: raw = c;
      3'd6: raw = n;
      default: raw = v;
    endcase
    take_o = raw ^ cond_i[3];
  end
endmodule

// File: rtl/reg_pred.sv
module reg_pred #(
  parameter int unsigned XLEN = 64
) (
  input  logic [2:0]      rcond_i,
  input  logic [XLEN-1:0] val_i,
  output logic            take_o
);
  logic is_zero, is_neg, raw;
  always_comb begin
    is_zero = (val_i == '0);
    is_neg  = val_i[XLEN-1];
    unique case (rcond_i[1:0])
      2'd1: raw = is_zero;
      2'd2: raw = is_zero | is_neg;
      2'd3: raw = is_neg;
      default: raw = 1'b0;
    endcase
    take_o = raw ^ rcond_i[2];
  end
endmodule

// File: rtl/fmov_pred_eval.sv
module fmov_pred_eval
  import fmov_pred_pkg::*;
#(
  parameter int unsigned XLEN     = 64,
  parameter int unsigned STATUS_W = 64
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [31:0]         insn_i,
  input  logic [STATUS_W-1:0] status_i,
  input  logic [7:0]          flags_i,
  input  logic [XLEN-1:0]     rs_val_i,
  output logic                valid_o,
  output logic                take_o,
  output logic [1:0]          cls_o
);
  localparam int unsigned FIDX_W = $clog2(FCC_N);

  logic [8:0] opf;
  logic       fmt_ok, is_fcc, is_int, is_reg;
  logic [1:0] fcc_arr [FCC_N];
  logic [1:0] fcc_sel;
  logic [3:0] nib;
  logic [XLEN-1:0] src_val;
  logic       t_fcc, t_int, t_reg, take_d;
  pred_cls_e  cls_d;

  assign opf    = insn_i[13:5];
  assign fmt_ok = (insn_i[31:30] == 2'b10) && (insn_i[24:19] == 6'h35);
  assign is_fcc = fmt_ok && !opf[8] && (opf[5:0] == 6'h03);
  assign is_int = fmt_ok &&  opf[8] && (opf[6:0] == 7'h03);
  assign is_reg = fmt_ok && !opf[8] && (opf[4:0] == 5'h07) && (opf[6:5] != 2'b00);

  for (genvar g = 0; g < FCC_N; g++) begin : g_fcc
    assign fcc_arr[g] = status_i[fcc_lsb(g) +: 2];
  end
  assign fcc_sel = fcc_arr[insn_i[12:11]];

  // 64-bit flags in upper nibble
  assign nib     = insn_i[12] ? flags_i[7:4] : flags_i[3:0];
  assign src_val = (insn_i[18:14] == 5'd0) ? '0 : rs_val_i;

  fcc_pred u_fcc (.cond_i(insn_i[17:14]), .fcc_i(fcc_sel), .take_o(t_fcc));
  icc_pred u_icc (.cond_i(insn_i[17:14]), .nzvc_i(nib),   .take_o(t_int));
  reg_pred #(.XLEN(XLEN)) u_reg (
    .rcond_i(insn_i[12:10]), .val_i(src_val), .take_o(t_reg)
  );

  always_comb begin
    if (is_fcc) begin
      cls_d = CLS_FCC;  take_d = t_fcc;
    end else if (is_int) begin
      cls_d = CLS_INT;  take_d = t_int;
    end else if (is_reg) begin
      cls_d = CLS_REG;  take_d = t_reg;
    end else begin
      cls_d = CLS_NONE; take_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      take_o  <= 1'b0;
      cls_o   <= CLS_NONE;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        take_o <= take_d;
        cls_o  <= cls_d;
      end
    end
  end

  logic unused_fidx;
  assign unused_fidx = ^FIDX_W;
endmodule

// File: rtl/fmov_pred_chk.sv
module fmov_pred_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic [31:0] insn_i,
  input logic        valid_o,
  input logic        take_o,
  input logic [1:0]  cls_o
);
  logic fmt, fcc_op, reg_op;
  assign fmt    = (insn_i[31:30] == 2'b10) && (insn_i[24:19] == 6'h35);
  assign fcc_op = fmt && !insn_i[13] && (insn_i[10:5] == 6'h03);
  assign reg_op = fmt && !insn_i[13] && (insn_i[9:5] == 5'h07) && (insn_i[11:10] != 2'b00);

  p_valid_rise_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  p_valid_fall_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(take_o) && $stable(cls_o)));
  p_none_skip_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && cls_o == 2'd0) |-> !take_o);
  p_never_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && fcc_op && insn_i[17:14] == 4'h0) |=> !take_o);
  p_always_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && fcc_op && insn_i[17:14] == 4'h8) |=> take_o);
  p_zero_spec_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && reg_op && insn_i[18:14] == 5'd0 && insn_i[12:10] == 3'b001) |=> take_o);
  p_reset_r11: assert property (@(posedge clk_i)
    !rst_ni |-> (!valid_o && !take_o && cls_o == 2'd0));
endmodule

bind fmov_pred_eval fmov_pred_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .insn_i(insn_i),
  .valid_o(valid_o), .take_o(take_o), .cls_o(cls_o)
);

// File: tb/sim_fmov_pred_eval.sv
`timescale 1ns/1ps
module sim_fmov_pred_eval;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] insn = '0;
  logic [63:0] status = '0;
  logic [7:0]  flags = '0;
  logic [63:0] rs_val = '0;
  logic        valid_o, take_o;
  logic [1:0]  cls_o;

  typedef struct { logic take; logic [1:0] cls; string req; } exp_t;
  exp_t sbq[$];
  int checks = 0, errors = 0;
  bit done = 0;
  logic last_take = 1'b0;
  logic [1:0] last_cls = 2'd0;

  always #5 clk = ~clk;

  fmov_pred_eval u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .insn_i(insn),
    .status_i(status), .flags_i(flags), .rs_val_i(rs_val),
    .valid_o(valid_o), .take_o(take_o), .cls_o(cls_o)
  );

  function automatic logic [31:0] mk(input logic [4:0] sel, input logic [8:0] opf);
    return {2'b10, 5'd0, 6'h35, sel, opf, 5'd0};
  endfunction

  function automatic logic ref_fcc(input logic [3:0] c, input logic [1:0] f);
    logic r;
    case (c[2:0])
      0: r = 0;
      1: r = f != 0;
      2: r = f == 1 || f == 2;
      3: r = f == 1 || f == 3;
      4: r = f == 1;
      5: r = f == 2 || f == 3;
      6: r = f == 2;
      default: r = f == 3;
    endcase
    return r ^ c[3];
  endfunction

  function automatic logic ref_int(input logic [3:0] c, input logic [3:0] f);
    logic r;
    case (c[2:0])
      0: r = 0;
      1: r = f[2];
      2: r = f[2] | (f[3] ^ f[1]);
      3: r = f[3] ^ f[1];
      4: r = f[0] | f[2];
      5: r = f[0];
      6: r = f[3];
      default: r = f[1];
    endcase
    return r ^ c[3];
  endfunction

  function automatic logic ref_reg(input logic [2:0] rc, input logic signed [63:0] v);
    logic r;
    case (rc[1:0])
      1: r = v == 0;
      2: r = v <= 0;
      default: r = v < 0;
    endcase
    return r ^ rc[2];
  endfunction

  task automatic drive(input logic [31:0] w, input logic t, input logic [1:0] c, input string req);
    @(negedge clk);
    insn = w; valid_i = 1'b1;
    sbq.push_back('{take: t, cls: c, req: req});
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (valid_o) begin
        exp_t e;
        checks++;
        if (sbq.size() == 0) begin
          errors++;
          $display("FAIL R10: unexpected valid_o, actual=1 expected=0");
        end else begin
          e = sbq.pop_front();
          if (take_o !== e.take || cls_o !== e.cls) begin
            errors++;
            $display("FAIL %s: insn=%h actual take=%0b cls=%0d expected take=%0b cls=%0d",
                     e.req, insn, take_o, cls_o, e.take, e.cls);
          end
        end
      end else begin
        checks++;
        if (take_o !== last_take || cls_o !== last_cls) begin
          errors++;
          $display("FAIL R10: hold actual take=%0b cls=%0d expected take=%0b cls=%0d",
                   take_o, cls_o, last_take, last_cls);
        end
      end
      last_take = take_o;
      last_cls  = cls_o;
    end
  end

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (valid_o !== 1'b0 || take_o !== 1'b0 || cls_o !== 2'd0) begin
      errors++;
      $display("FAIL R11: reset actual v=%0b t=%0b c=%0d expected 0 0 0", valid_o, take_o, cls_o);
    end
    rst_n = 1'b1;

    // R1, R2, R3: each field, each value, every condition
    for (int idx = 0; idx < 4; idx++) begin
      for (int fv = 0; fv < 4; fv++) begin
        for (int c = 0; c < 16; c++) begin
          logic [1:0] other;
          other = 2'(fv + 1 + idx);
          status = '0;
          status[11:10] = other; status[33:32] = other;
          status[35:34] = other; status[37:36] = other;
          case (idx)
            0: status[11:10] = 2'(fv);
            1: status[33:32] = 2'(fv);
            2: status[35:34] = 2'(fv);
            default: status[37:36] = 2'(fv);
          endcase
          drive(mk({1'b0, 4'(c)}, {1'b0, 2'(idx), 6'h03}),
                ref_fcc(4'(c), 2'(fv)), 2'd1, (c >= 8) ? "R3" : (idx != 0 ? "R1" : "R2"));
        end
      end
    end

    // R4, R5: both nibbles, all flag patterns
    for (int hi = 0; hi < 2; hi++) begin
      for (int f = 0; f < 16; f++) begin
        for (int c = 0; c < 16; c++) begin
          flags = hi ? {4'(f), 4'(~f)} : {4'(~f), 4'(f)};
          drive(mk({1'b0, 4'(c)}, hi ? 9'h183 : 9'h103),
                ref_int(4'(c), 4'(f)), 2'd2, hi ? "R4" : "R5");
        end
      end
    end

    // R6, R7, R8: register conditions
    begin
      logic [63:0] vals [5];
      vals[0] = 64'd0; vals[1] = 64'd5; vals[2] = -64'sd3;
      vals[3] = 64'h8000_0000_0000_0000; vals[4] = 64'h7fff_ffff_ffff_ffff;
      for (int rc = 1; rc < 8; rc++) begin
        if (rc == 4) continue;
        for (int k = 0; k < 5; k++) begin
          rs_val = vals[k];
          drive(mk(5'd9, {1'b0, 3'(rc), 5'h07}), ref_reg(3'(rc), vals[k]), 2'd3,
                rc[2] ? "R7" : "R6");
          drive(mk(5'd0, {1'b0, 3'(rc), 5'h07}), ref_reg(3'(rc), 64'sd0), 2'd3, "R8");
        end
      end
    end

    // R9: unrecognised
    rs_val = 64'd0;
    drive(mk(5'd0, 9'h007), 1'b0, 2'd0, "R9");
    drive(mk(5'd0, 9'h087), 1'b0, 2'd0, "R9");
    drive(mk(5'd8, 9'h005), 1'b0, 2'd0, "R9");
    drive(mk(5'd8, 9'h103) ^ 32'h0008_0000, 1'b0, 2'd0, "R9");
    drive(mk(5'd8, 9'h003) ^ 32'h4000_0000, 1'b0, 2'd0, "R9");

    // R10: back-to-back strobes then an idle gap
    flags = 8'h04;
    @(negedge clk);
    insn = mk(5'd1, 9'h103); valid_i = 1'b1;
    sbq.push_back('{take: 1'b1, cls: 2'd2, req: "R10"});
    @(negedge clk);
    insn = mk(5'd0, 9'h103);
    sbq.push_back('{take: 1'b0, cls: 2'd2, req: "R10"});
    @(negedge clk);
    valid_i = 1'b0; insn = mk(5'd8, 9'h003);
    repeat (4) @(negedge clk);

    checks++;
    if (sbq.size() != 0) begin
      errors++;
      $display("FAIL R10: pending results actual=%0d expected=0", sbq.size());
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule